// File: doc/BRIEF.md
# Auto-Detecting Dual-Mode Serial Control Port

This block is a slave serial control port. It gives an external host read and write access to a bank of eight 8-bit control registers. The host opens a session by pulling chip select low. On that falling edge the port samples the serial clock and picks one of two conventions for the whole session. If the clock is high, one bidirectional pin carries both directions and data bytes travel least-significant bit first. If the clock is low, the port uses separate input and output pins, acts as an SPI slave with clock polarity 0 and phase 0, and sends data bytes most-significant bit first.

Every session has 16 serial clocks. The first eight carry a command byte that holds the read/write flag and the register address. The last eight carry the data byte, which is written to or read from that register. All pin inputs are synchronized into the system clock domain before any edge is detected. The system clock must run at least four times as fast as the serial clock. The register contents are available in parallel to the rest of the chip.

Top module: `sermp_port`

## Requirements
- R1: After reset, register 0 holds 80h, registers 1 to 7 hold 00h, and the data-out enable is low.
- R2: The serial clock level sampled at the chip-select falling edge selects the mode: high selects bidirectional mode, where `data1_in` is the input and `data2_in` is ignored; low selects split mode, where `data2_in` is the input and `data1_in` is ignored.
- R3: In serial arrival order, the command byte carries R/W first (1 = read), then four don't-care bits, then A2, A1, A0. In split mode (MSB-first) this places R/W at byte bit 7 and the address at bits 2:0. In bidirectional mode (LSB-first) it places R/W at bit 0 and A2, A1, A0 at bits 5, 6, 7.
- R4: Data bytes, both written and read, travel MSB-first in split mode and LSB-first in bidirectional mode.
- R5: In a read, the first data bit appears on `data1_out` after the eighth command bit and changes only on SCLK falling edges. Bits the host shifts in during a read are ignored, and no register changes.
- R6: A write changes its register only after all 16 bits have arrived. If chip select rises earlier, no register changes.
- R7: Unused bits are stored and read as 0. The writable masks are: register 0 FFh, register 1 07h, register 2 3Fh, register 3 9Fh, register 7 0Fh, registers 4 to 6 FFh.
- R8: `data1_oe` is low whenever chip select has been seen high. In split mode it is high for the whole session. In bidirectional mode it is high only during the data phase of a read.
- R9: If the sixteenth SCLK rising edge reaches the port in the same synchronized cycle as chip select returning high, the write still commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| data1_in | input | 1 | Pin 1 input (bidirectional-mode data) |
| data2_in | input | 1 | Pin 2 input (split-mode receive data) |
| data1_out | output | 1 | Pin 1 output value |
| data1_oe | output | 1 | Pin 1 output enable (0 = high impedance) |
| regs_out | output | 64 | All eight registers, register n at bits 8n+7:8n |

## Verification
Two events can fall in the same system cycle: closing a write session and the final bit edge. The bench provokes this by switching SCLK high and chip select high in one step on the sixteenth bit, in both modes. It then judges the result on `regs_out`: the written byte must be present. A second race is also exercised. During a read the host keeps driving random bits while the port shifts out data. The read value and an unchanged register bank must both hold.

// File: rtl/sermp_pkg.sv
// Shared constants and helpers for the serial control port.
// Assumes 8-bit registers; masks give the implemented bits of each register.
package sermp_pkg;

    localparam int REG_W = 8;

    typedef enum logic {
        PM_SPLIT = 1'b0,
        PM_BIDIR = 1'b1
    } port_mode_e;

    // Implemented-bit mask of register idx; all other bits stay 0.
    function automatic logic [REG_W-1:0] field_mask(input int unsigned idx);
        case (idx)
            1:       return 8'h07;
            2:       return 8'h3F;
            3:       return 8'h9F;
            7:       return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    // Bit reversal for LSB-first transfers.
    function automatic logic [REG_W-1:0] flip(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] r;
        for (int i = 0; i < REG_W; i++) r[i] = v[REG_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/sermp_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; RST_VAL sets the idle level per bit.
module sermp_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the pin values through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], din};
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/sermp_regbank.sv
// Register bank: one write port, all contents exposed in parallel.
// Assumes write address is in range; unimplemented bits are forced to 0.
module sermp_regbank
    import sermp_pkg::*;
#(
    parameter int              NUM_REGS  = 8,
    parameter int              ADDR_W    = $clog2(NUM_REGS),
    parameter logic [REG_W-1:0] REG0_INIT = 8'h80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [REG_W-1:0] INIT = (g == 0) ? REG0_INIT : '0;
        // Hold register g; load masked data when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_flat[g*REG_W +: REG_W] <= INIT;
            else if (wr_en && wr_addr == ADDR_W'(g))
                regs_flat[g*REG_W +: REG_W] <= wr_data & field_mask(g);
        end
    end

endmodule

// File: rtl/sermp_engine.sv
// Session engine: mode detection, bit counting, command decode, data shift.
// Assumes synchronized inputs and SCLK at most a quarter of clk.
module sermp_engine
    import sermp_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_s,
    input  logic                      sclk_s,
    input  logic                      d1_s,
    input  logic                      d2_s,
    input  logic [NUM_REGS*REG_W-1:0] regs_flat,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [REG_W-1:0]          wr_data,
    output logic                      rd_load,
    output logic                      data1_out,
    output logic                      data1_oe
);

    localparam int FRAME = 2 * REG_W;
    localparam int CNT_W = $clog2(FRAME + 1);
    localparam logic [CNT_W-1:0] C_CMD_LAST = CNT_W'(REG_W - 1);
    localparam logic [CNT_W-1:0] C_DATA     = CNT_W'(REG_W);
    localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME - 1);
    localparam logic [CNT_W-1:0] C_FRAME    = CNT_W'(FRAME);

    logic             cs_q, sclk_q, active, rw_q;
    port_mode_e       mode;
    logic [CNT_W-1:0] cnt;
    logic [REG_W-2:0] cmd_sr, dat_sr;
    logic [REG_W-1:0] out_sr;

    logic             cs_fall, sclk_rise, sclk_fall, in_bit;
    logic [ADDR_W-1:0] cmd_addr;
    logic [REG_W-1:0] dat_full, sel_byte;

    // Edge detection and per-session input selection.
    always_comb begin
        cs_fall   = cs_q & ~cs_s;
        sclk_rise = ~sclk_q & sclk_s;
        sclk_fall = sclk_q & ~sclk_s;
        in_bit    = (mode == PM_BIDIR) ? d1_s : d2_s;
        cmd_addr  = {cmd_sr[ADDR_W-2:0], in_bit};
        dat_full  = {dat_sr, in_bit};
        sel_byte  = regs_flat[cmd_addr*REG_W +: REG_W];
    end

    assign data1_out = out_sr[REG_W-1];

    // Session state machine: one pass per 16-bit frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q     <= 1'b1;
            sclk_q   <= 1'b0;
            mode     <= PM_SPLIT;
            active   <= 1'b0;
            rw_q     <= 1'b0;
            cnt      <= '0;
            cmd_sr   <= '0;
            dat_sr   <= '0;
            out_sr   <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            rd_load  <= 1'b0;
            data1_oe <= 1'b0;
        end else begin
            cs_q    <= cs_s;
            sclk_q  <= sclk_s;
            wr_en   <= 1'b0;
            rd_load <= 1'b0;
            if (cs_fall) begin
                mode     <= sclk_s ? PM_BIDIR : PM_SPLIT;
                active   <= 1'b1;
                cnt      <= '0;
                data1_oe <= ~sclk_s;
            end else begin
                if (active && sclk_rise && cnt < C_FRAME) begin
                    cnt <= cnt + 1'b1;
                    if (cnt < C_DATA) begin
                        cmd_sr <= {cmd_sr[REG_W-3:0], in_bit};
                        if (cnt == C_CMD_LAST) begin
                            rw_q    <= cmd_sr[REG_W-2];
                            wr_addr <= cmd_addr;
                            if (cmd_sr[REG_W-2]) begin
                                rd_load  <= 1'b1;
                                data1_oe <= 1'b1;
                                out_sr   <= (mode == PM_BIDIR) ? flip(sel_byte) : sel_byte;
                            end
                        end
                    end else begin
                        dat_sr <= dat_full[REG_W-2:0];
                        if (cnt == C_LAST && !rw_q) begin
                            wr_en   <= 1'b1;
                            wr_data <= (mode == PM_BIDIR) ? flip(dat_full) : dat_full;
                        end
                    end
                end
                if (active && sclk_fall && rw_q && cnt > C_DATA && cnt < C_FRAME)
                    out_sr <= {out_sr[REG_W-2:0], 1'b0};
                if (cs_s) begin
                    active   <= 1'b0;
                    rd_load  <= 1'b0;
                    data1_oe <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sermp_port.sv
// Top of the serial control port: synchronizers, session engine, registers.
// Assumes clk is at least 4x SCLK; pins may change asynchronously to clk.
module sermp_port
    import sermp_pkg::*;
#(
    parameter int               NUM_REGS    = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [REG_W-1:0] REG0_INIT   = 8'h80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      sclk,
    input  logic                      data1_in,
    input  logic                      data2_in,
    output logic                      data1_out,
    output logic                      data1_oe,
    output logic [NUM_REGS*REG_W-1:0] regs_out
);

    localparam int ADDR_W = $clog2(NUM_REGS);

    logic [3:0]        pins_s;
    logic              cs_sync, sclk_sync, d1_sync, d2_sync;
    logic              wr_en, rd_load;
    logic [ADDR_W-1:0] wr_addr;
    logic [REG_W-1:0]  wr_data;

    sermp_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1000)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk, data1_in, data2_in}),
        .dout  (pins_s)
    );

    assign {cs_sync, sclk_sync, d1_sync, d2_sync} = pins_s;

    sermp_engine #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_sync),
        .sclk_s    (sclk_sync),
        .d1_s      (d1_sync),
        .d2_s      (d2_sync),
        .regs_flat (regs_out),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_load   (rd_load),
        .data1_out (data1_out),
        .data1_oe  (data1_oe)
    );

    sermp_regbank #(
        .NUM_REGS  (NUM_REGS),
        .ADDR_W    (ADDR_W),
        .REG0_INIT (REG0_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (regs_out)
    );

endmodule

// File: rtl/sermp_chk.sv
// Property checker for sermp_port, attached by bind below.
// Assumes it observes the synchronized chip select and internal strobes.
module sermp_chk
    import sermp_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cs_s,
    input logic                      data1_oe,
    input logic                      wr_en,
    input logic                      rd_load,
    input logic [NUM_REGS*REG_W-1:0] regs_flat
);

    // R8: driver released once chip select is seen high
    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_s) |-> !data1_oe);

    // R6: registers only change right after a committed write
    p_regs_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(regs_flat));

    // R3: a session is either a read or a write, never both
    p_wr_rd_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_load));

    // R5: loading read data coincides with driving the pin
    p_rd_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |-> data1_oe);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_resv
        // R7: unimplemented bits never hold a 1
        p_resv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (regs_flat[g*REG_W +: REG_W] & ~field_mask(g)) == '0);
    end

endmodule

bind sermp_port sermp_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_sync),
    .data1_oe  (data1_oe),
    .wr_en     (wr_en),
    .rd_load   (rd_load),
    .regs_flat (regs_out)
);

// File: tb/sermp_port_tb_top.sv
// Self-checking bench: directed corners plus seeded random sessions.
module sermp_port_tb_top;

    localparam int HP = 6;   // SCLK half period in clk cycles

    logic        clk = 1'b0;
    logic        rst_n, cs_n, sclk, data1_in, data2_in;
    logic        data1_out, data1_oe;
    logic [63:0] regs_out;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [7:0]  exp_r [8];

    always #5 clk = ~clk;

    sermp_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .data1_in  (data1_in),
        .data2_in  (data2_in),
        .data1_out (data1_out),
        .data1_oe  (data1_oe),
        .regs_out  (regs_out)
    );

    function automatic logic [7:0] bmask(input int a);
        case (a)
            1: return 8'h07;
            2: return 8'h3F;
            3: return 8'h9F;
            7: return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int a = 0; a < 8; a++)
            chk(regs_out[a*8 +: 8] === exp_r[a], tag, regs_out[a*8 +: 8], exp_r[a]);
    endtask

    // One host session; nbits < 16 aborts, simult raises CS with the last SCLK edge.
    task automatic session(input bit bidir, input bit rw, input logic [2:0] a,
                           input logic [7:0] d, input int nbits, input bit simult,
                           output logic [7:0] rd, output bit oe_bad);
        logic [15:0] ser;
        ser[15]    = rw;
        ser[14:11] = 4'($urandom);
        ser[10:8]  = a;
        for (int j = 0; j < 8; j++)
            ser[7-j] = rw ? 1'($urandom) : (bidir ? d[j] : d[7-j]);
        rd = '0;
        oe_bad = 1'b0;
        sclk = bidir;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            if (bidir) begin data1_in = ser[15-i]; data2_in = 1'($urandom); end
            else       begin data2_in = ser[15-i]; data1_in = 1'($urandom); end
            repeat (HP) @(negedge clk);
            if (i >= 8) begin
                if (bidir) rd[i-8] = data1_out;
                else       rd[15-i] = data1_out;
                if (rw && !data1_oe) oe_bad = 1'b1;
            end
            if (!rw && bidir && data1_oe) oe_bad = 1'b1;
            if (!bidir && !data1_oe) oe_bad = 1'b1;
            sclk = 1'b1;
            if (simult && i == nbits - 1) cs_n = 1'b1;
            repeat (HP) @(negedge clk);
        end
        if (!simult) begin
            sclk = bidir;
            repeat (HP) @(negedge clk);
            cs_n = 1'b1;
        end
        repeat (6) @(negedge clk);
        if (!rw && nbits == 16) exp_r[a] = d & bmask(a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        bit oe_bad;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; data1_in = 1'b0; data2_in = 1'b0;
        exp_r[0] = 8'h80;
        for (int a = 1; a < 8; a++) exp_r[a] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        check_regs("R1 reset value");
        chk(data1_oe === 1'b0, "R1 oe at reset", data1_oe, 0);

        // Split mode write into masked register, read back both ways
        session(0, 0, 3'd3, 8'hFF, 16, 0, rd, oe_bad);
        chk(regs_out[24 +: 8] === 8'h9F, "R7 masked write", regs_out[24 +: 8], 8'h9F);
        chk(!oe_bad, "R8 split oe during session", oe_bad, 0);
        chk(data1_oe === 1'b0, "R8 oe after CS high", data1_oe, 0);
        session(0, 1, 3'd3, 8'h00, 16, 0, rd, oe_bad);
        chk(rd === 8'h9F, "R3 R4 split read", rd, 8'h9F);
        session(1, 1, 3'd3, 8'h00, 16, 0, rd, oe_bad);
        chk(rd === 8'h9F, "R2 R4 bidir read", rd, 8'h9F);
        chk(!oe_bad, "R8 bidir read oe", oe_bad, 0);

        // Bit order with asymmetric values
        session(1, 0, 3'd5, 8'h1E, 16, 0, rd, oe_bad);
        chk(regs_out[40 +: 8] === 8'h1E, "R4 bidir write order", regs_out[40 +: 8], 8'h1E);
        chk(!oe_bad, "R8 bidir write keeps pin released", oe_bad, 0);
        session(0, 0, 3'd4, 8'hC3 ^ 8'h05, 16, 0, rd, oe_bad);
        chk(regs_out[32 +: 8] === 8'hC6, "R4 split write order", regs_out[32 +: 8], 8'hC6);
        session(0, 1, 3'd5, 8'h00, 16, 0, rd, oe_bad);
        chk(rd === 8'h1E, "R2 R5 cross-mode read", rd, 8'h1E);

        // Aborted writes
        session(0, 0, 3'd2, 8'h2A, 12, 0, rd, oe_bad);
        check_regs("R6 split abort");
        session(1, 0, 3'd6, 8'h77, 15, 0, rd, oe_bad);
        check_regs("R6 bidir abort");

        // Last edge together with CS release
        session(0, 0, 3'd6, 8'h5B, 16, 1, rd, oe_bad);
        chk(regs_out[48 +: 8] === 8'h5B, "R9 split simultaneous end", regs_out[48 +: 8], 8'h5B);
        session(1, 0, 3'd1, 8'hFD, 16, 1, rd, oe_bad);
        chk(regs_out[8 +: 8] === 8'h05, "R9 R7 bidir simultaneous end", regs_out[8 +: 8], 8'h05);

        // Read with random host traffic leaves the bank alone
        session(1, 1, 3'd0, 8'h00, 16, 0, rd, oe_bad);
        chk(rd === 8'h80, "R5 read register 0", rd, 8'h80);
        check_regs("R5 read changes nothing");

        // Random sessions
        for (int k = 0; k < 40; k++) begin
            bit bd, rw;
            logic [2:0] a;
            logic [7:0] d;
            bd = 1'($urandom);
            rw = 1'($urandom);
            a  = 3'($urandom);
            d  = 8'($urandom);
            session(bd, rw, a, d, 16, 0, rd, oe_bad);
            if (rw) chk(rd === exp_r[a], "R3 R4 R5 random read", rd, exp_r[a]);
            chk(regs_out[a*8 +: 8] === exp_r[a], "R2 R6 R7 random register", regs_out[a*8 +: 8], exp_r[a]);
            chk(!oe_bad && data1_oe === 1'b0, "R8 random oe", {oe_bad, data1_oe}, 0);
        end
        check_regs("R6 final bank");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule